// File: doc/BRIEF.md
# I2C Ferroelectric Memory Target

This block is the bus-facing side of a byte-addressable nonvolatile store. It listens on an I2C bus, with both lines brought into the system clock domain through short synchronisers. It answers one 7-bit device address, which is built from a fixed 4-bit type code and three strap inputs. After it accepts the device byte, a write transfer carries a two-byte memory address followed by any number of data bytes. A read transfer streams bytes out from an internal pointer, and that pointer advances by one after every byte.

Every write commits within the ninth bit slot of its byte. The target therefore never withholds an acknowledge to signal that it is busy, and a master never has to poll it. One protect input shuts off all updates to the array, while the bus protocol runs exactly as it does without protection. The array is modelled as on-chip registers of `2**ADDR_W` bytes, which gives 8192 bytes by default.

Top module: `i2c_fram_target`

## Requirements
- R1: Reset releases SDA (`sda_oe_o` = 0) and clears the address pointer to zero, so a read issued straight after reset returns the byte at address 0.
- R2: A device byte whose upper four bits are 1010, whose next three bits equal `strap_i[2:1:0]` and whose least significant bit is the direction (0 write, 1 read) is acknowledged by pulling SDA low in the ninth bit slot.
- R3: A device byte with a wrong type code or wrong strap bits is not acknowledged. The target then leaves SDA released, and the array unchanged, until the next start condition.
- R4: In a write transfer, the two bytes after the device byte (high byte first) are each acknowledged and load the pointer. Address bits at or above ADDR_W are ignored.
- R5: Each data byte in a write transfer is acknowledged, stored at the pointer, and the pointer then advances by one.
- R6: In a read transfer, the target drives the byte at the pointer MSB first, one bit per SCL period, and advances the pointer. A master acknowledge (SDA low in the ninth slot) makes it continue with the next byte.
- R7: A master not-acknowledge (SDA high in the ninth slot) ends the read. SDA stays released on every later SCL clock until the next start condition.
- R8: While `wp_i` is high, write data bytes are still acknowledged and the pointer still advances, but no array byte changes.
- R9: The pointer wraps from `2**ADDR_W-1` to 0, for both writes and reads.
- R10: A read transfer that follows a stop, with no address phase, starts at the address left by the previous transfer.
- R11: A start condition (SDA falling while SCL is high) restarts device-byte reception from any state, which allows a repeated start. A stop condition (SDA rising while SCL is high) returns the target to idle with SDA released.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (the wired-AND of all drivers) |
| strap_i | input | 3 | Strap bits that form the low part of the device address |
| wp_i | input | 1 | Write protect; high blocks every array update (tie low when unused) |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench builds the target with ADDR_W = 9 and two synchroniser stages. The 512-byte array makes the wrap from 0x1FF to 0x000 reachable with short transfers. An address high byte of 0xE1 then shows that bits 9 to 15 are discarded. The array stays small enough that a behavioural byte array in the bench can mirror every write, protected or not. Two synchroniser stages keep the target's reaction within a few clocks of each SCL edge, so a bus phase of eight system clocks leaves a clear margin when the bench samples acknowledges and read bits.

// File: rtl/i2c_fram_pkg.sv
package i2c_fram_pkg;
   localparam logic [3:0] TYPE_CODE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } fsm_e;
endpackage

// File: rtl/i2c_fram_busmon.sv
module i2c_fram_busmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   generate
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic scl_d, sda_d;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[i] <= 1'b1;
               sda_q[i] <= 1'b1;
            end else if (i == 0) begin
               scl_q[i] <= scl_i;
               sda_q[i] <= sda_i;
            end else begin
               scl_q[i] <= scl_q[(i > 0) ? i - 1 : 0];
               sda_q[i] <= sda_q[(i > 0) ? i - 1 : 0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q[SYNC_STAGES-1];
         sda_d <= sda_q[SYNC_STAGES-1];
      end
   end

   assign scl_lvl  = scl_q[SYNC_STAGES-1];
   assign sda_lvl  = sda_q[SYNC_STAGES-1];
   assign scl_rise = scl_lvl & ~scl_d;
   assign scl_fall = ~scl_lvl & scl_d;
   assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_fram_array.sv
module i2c_fram_array #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_protect,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic              commit;

   assign commit = wr_en & ~wr_protect;

   always_ff @(posedge clk) begin
      if (commit) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2c_fram_ctrl.sv
module i2c_fram_ctrl
   import i2c_fram_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_lvl,
   input  logic [2:0]        strap,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_en,
   output logic [7:0]        wr_data,
   output logic              sda_oe,
   output fsm_e              st
);
   logic [2:0]  cnt;
   logic [7:0]  shreg, tx, ahi;
   logic        have_byte, rw, mack;
   logic [15:0] full_addr;

   assign full_addr = {ahi, shreg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         tx        <= '0;
         ahi       <= '0;
         have_byte <= 1'b0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_ev) begin
            st        <= ST_IDLE;
            sda_oe    <= 1'b0;
            have_byte <= 1'b0;
         end else if (start_ev) begin
            st        <= ST_DEV;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            have_byte <= 1'b0;
         end else begin
            case (st)
               ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_lvl};
                     cnt   <= cnt + 3'd1;
                     if (cnt == 3'd7) have_byte <= 1'b1;
                  end else if (scl_fall && have_byte) begin
                     have_byte <= 1'b0;
                     sda_oe    <= 1'b1;
                     case (st)
                        ST_DEV: begin
                           if (shreg[7:1] == {TYPE_CODE, strap}) begin
                              rw <= shreg[0];
                              st <= ST_DEV_ACK;
                           end else begin
                              sda_oe <= 1'b0;
                              st     <= ST_SKIP;
                           end
                        end
                        ST_AHI: begin
                           ahi <= shreg;
                           st  <= ST_AHI_ACK;
                        end
                        ST_ALO: begin
                           ptr <= full_addr[ADDR_W-1:0];
                           st  <= ST_ALO_ACK;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_data <= shreg;
                           st      <= ST_WR_ACK;
                        end
                     endcase
                  end
               end
               ST_DEV_ACK, ST_RD_ACK: begin
                  if (scl_rise) mack <= ~sda_lvl;
                  if (scl_fall) begin
                     if ((st == ST_DEV_ACK && rw) || (st == ST_RD_ACK && mack)) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt    <= '0;
                        ptr    <= ptr + 1'b1;
                        st     <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= (st == ST_DEV_ACK) ? ST_AHI : ST_SKIP;
                     end
                  end
               end
               ST_AHI_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= ST_ALO;
               end
               ST_ALO_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= ST_WR;
               end
               ST_WR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  ptr    <= ptr + 1'b1;
                  st     <= ST_WR;
               end
               ST_RD: if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     st     <= ST_RD_ACK;
                  end else begin
                     tx     <= {tx[6:0], 1'b0};
                     sda_oe <= ~tx[6];
                     cnt    <= cnt + 3'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_fram_target.sv
module i2c_fram_target
   import i2c_fram_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       sda_oe_o
);
   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 8..16");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
   logic [ADDR_W-1:0] ptr;
   logic              wr_en;
   logic [7:0]        wr_data, rd_data;
   fsm_e              st;

   i2c_fram_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
   );

   i2c_fram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(sda_lvl),
      .strap(strap_i), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
      .wr_data(wr_data), .sda_oe(sda_oe_o), .st(st)
   );

   i2c_fram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk(clk), .wr_en(wr_en), .wr_protect(wp_i), .wr_addr(ptr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
   );
endmodule

// File: rtl/i2c_fram_chk.sv
module i2c_fram_chk
   import i2c_fram_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic start_ev,
   input logic stop_ev,
   input logic sda_oe,
   input fsm_e st
);
   // R12
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   // R7
   drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (st inside {ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK, ST_RD}));

   // R11
   start_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_DEV));

   // R11
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE && !sda_oe));

   // R3
   skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP && !start_ev && !stop_ev) |=> (st == ST_SKIP && !sda_oe));
endmodule

bind i2c_fram_target i2c_fram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
   .stop_ev(stop_ev), .sda_oe(sda_oe_o), .st(st)
);

// File: tb/i2c_fram_target_tb.sv
module i2c_fram_target_tb;
   localparam int AW   = 9;
   localparam int SIZE = 1 << AW;
   localparam int Q    = 8;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic master_owns = 1'b1;
   logic prev_oe = 1'b0;
   int   checks = 0, fails = 0, ptr = 0;
   logic [7:0] model [SIZE];

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_fram_target #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the bus ownership the model expects
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe != prev_oe) chk("R12 drive change while SCL high", int'(scl_m), 0);
         if (master_owns && scl_m) chk("R3/R7 target drives in master phase", int'(sda_oe), 0);
      end
      prev_oe = sda_oe;
   end

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_start();
      master_owns = 1'b1;
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic send_stop();
      master_owns = 1'b1;
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ackb);
      master_owns = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q();
      end
      master_owns = 1'b0;
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); ackb = sda_line; scl_m = 1'b0; q();
   endtask

   task automatic rd_byte(input logic nack, output logic [7:0] b);
      master_owns = 1'b0;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl_m = 1'b1; q(); b[i] = sda_line; scl_m = 1'b0;
      end
      q(); sda_m = nack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
      if (nack) master_owns = 1'b1;
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
      logic a;
      send_start();
      wr_byte({4'b1010, STRAP, 1'b0}, a); chk("R2 device write ack", a, 0);
      wr_byte(hi, a); chk("R4 high address ack", a, 0);
      wr_byte(lo, a); chk("R4 low address ack", a, 0);
      ptr = ((int'(hi) << 8) | int'(lo)) % SIZE;
   endtask

   task automatic do_write(input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] data [$], input string tag);
      logic a;
      set_addr(hi, lo);
      foreach (data[k]) begin
         wr_byte(data[k], a); chk(tag, a, 0);
         if (!wp) model[ptr] = data[k];
         ptr = (ptr + 1) % SIZE;
      end
      send_stop();
   endtask

   task automatic do_read(input int n, input string tag);
      logic a;
      logic [7:0] b;
      send_start();
      wr_byte({4'b1010, STRAP, 1'b1}, a); chk("R2 device read ack", a, 0);
      for (int k = 0; k < n; k++) begin
         rd_byte(k == n - 1, b);
         chk(tag, b, model[ptr]);
         ptr = (ptr + 1) % SIZE;
      end
      send_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] b;
      foreach (model[i]) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      q();
      chk("R1 SDA released after reset", sda_oe, 0);

      do_write(8'h00, 8'h00, '{8'h11, 8'h22}, "R5 data ack");
      rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; ptr = 0; q();
      do_read(1, "R1 read after reset at address 0");

      // high byte 0xE1: only bit 8 survives with AW = 9
      do_write(8'hE1, 8'h30, '{8'hC3, 8'h3C, 8'h96}, "R5 data ack");
      set_addr(8'hE1, 8'h30);
      do_read(2, "R6 R11 random read after repeated start");
      do_read(1, "R10 current address read");

      do_write(8'h01, 8'hFF, '{8'hA5, 8'h5A}, "R9 data ack across wrap");
      set_addr(8'h01, 8'hFF);
      do_read(2, "R9 read across wrap");

      wp = 1'b1;
      do_write(8'h01, 8'h30, '{8'hFF, 8'h00}, "R8 protected data still acked");
      wp = 1'b0;
      set_addr(8'h01, 8'h30);
      do_read(2, "R8 array unchanged under protect");

      send_start();
      wr_byte({4'b1010, 3'b100, 1'b0}, a); chk("R3 strap mismatch no ack", a, 1);
      wr_byte(8'h01, a); chk("R3 ignored byte no ack", a, 1);
      wr_byte(8'h31, a); chk("R3 ignored byte no ack", a, 1);
      wr_byte(8'h77, a); chk("R3 ignored data no ack", a, 1);
      send_stop();
      send_start();
      wr_byte({4'b1011, STRAP, 1'b1}, a); chk("R3 type code mismatch no ack", a, 1);
      send_stop();
      set_addr(8'h01, 8'h31);
      do_read(1, "R3 array unchanged after ignored transfer");

      set_addr(8'h01, 8'h32);
      send_start();
      wr_byte({4'b1010, STRAP, 1'b1}, a); chk("R2 device read ack", a, 0);
      rd_byte(1'b1, b); chk("R6 single read byte", b, model[ptr]);
      ptr = (ptr + 1) % SIZE;
      wr_byte(8'h00, a); chk("R7 released after master nack", a, 1);
      send_stop();
      chk("R11 released after stop", sda_oe, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule